// File: doc/BRIEF.md
# Page Program Byte Stager

This block gathers the data bytes of one serial-flash page program before the program is issued. A byte on the 8-bit data input is captured on a rising clock edge where the write-enable input and a one-cycle shift strobe are both high. Bytes may arrive with any number of idle cycles between them. The number of bytes held is reported at all times.

The storage depth equals a page-size parameter, which must be a power of two from 4 to 256. If more bytes are shifted in than one page holds, the stager keeps only the most recent page-size bytes and silently drops the earliest ones. It does not stall and it raises no overflow flag. The command sequencer then drains the bytes in arrival order, oldest retained byte first, through a valid/pop read port. After the program, a flush clears the stager.

Top module: `page_stage_buf`

## Requirements
- R1: A byte is captured only on a rising edge where `wr_en_i` and `shift_i` are both high. Each capture with no pop, no flush and no drop raises `count_o` by one on that edge.
- R2: An edge with `shift_i` high and `wr_en_i` low, or with `wr_en_i` high and `shift_i` low, changes neither `count_o` nor the stored bytes.
- R3: While `rd_valid_o` is high, `rd_data_o` shows the oldest held byte. It holds steady until a pop, a flush or a drop occurs.
- R4: Bytes captured on non-consecutive edges are stored in arrival order, and up to `PAGE_BYTES` of them are held, with `count_o` equal to the number held.
- R5: A capture while `count_o` equals `PAGE_BYTES` discards the oldest byte and stores the new one, so `count_o` stays at `PAGE_BYTES` and the last `PAGE_BYTES` bytes remain in order.
- R6: `flush_i` empties the stager on the next edge (`count_o` becomes 0). It takes priority over a capture or a pop in the same cycle.
- R7: `empty_o` is high exactly when `count_o` is zero, and `rd_valid_o` is its inverse. A pop while empty has no effect.
- R8: A pop on an edge removes the oldest byte and lowers `count_o` by one. A pop and a capture on the same edge leave `count_o` unchanged, including when full, and keep arrival order.
- R9: After `rst_ni` is released the stager is empty, with `count_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable; must be high for a capture |
| shift_i | input | 1 | One-cycle strobe per data byte |
| data_i | input | 8 | Byte to capture |
| flush_i | input | 1 | Synchronous clear, highest priority |
| pop_i | input | 1 | Remove the byte shown on the read port |
| rd_data_o | output | 8 | Oldest held byte |
| rd_valid_o | output | 1 | High when at least one byte is held |
| count_o | output | $clog2(PAGE_BYTES)+1 | Number of bytes held |
| empty_o | output | 1 | High when no byte is held |

## Verification
The main loop feeds the stager several kinds of input:
- back-to-back captures, which check that each strobe is taken once;
- captures separated by idle cycles, which check that capture does not depend on consecutive strobes;
- strobes with write enable low, and write enable with no strobe, which check that both terms of the capture condition are needed;
- interleaved captures and pops, which show whether the read and write pointers move independently.

Directed runs overfill an eight-byte page by three bytes and drain it, which tells a keep-last policy from keep-first or blocking. Further runs cover a capture with a pop while full, a flush together with a capture, and a pop while empty.

// File: rtl/page_stage_pkg.sv
package page_stage_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/page_stage_ctrl.sv
module page_stage_ctrl #(
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned AW = $clog2(PAGE_BYTES),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic          wr_fire_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o
);
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic push_ok, pop_ok, full, drop, rd_adv;

  assign full    = (cnt_q == CW'(PAGE_BYTES));
  assign push_ok = push_i & ~flush_i;
  assign pop_ok  = pop_i & (cnt_q != '0) & ~flush_i;
  // full page: new byte evicts oldest unless a pop already makes room
  assign drop    = push_ok & full & ~pop_ok;
  assign rd_adv  = pop_ok | drop;
  assign cnt_d   = cnt_q + CW'(push_ok) - CW'(rd_adv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (rd_adv)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_d;
    end
  end

  assign wr_fire_o = push_ok;
  assign wr_ptr_o  = wr_q;
  assign rd_ptr_o  = rd_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/page_stage_mem.sv
module page_stage_mem
  import page_stage_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned AW = $clog2(PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  byte_t         wr_data_i,
  input  logic [AW-1:0] rd_ptr_i,
  output byte_t         rd_data_o
);
  byte_t slot_q [PAGE_BYTES];

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q[i] <= '0;
      else if (we_i && (wr_ptr_i == AW'(i)))        slot_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_ptr_i];
endmodule

// File: rtl/page_stage_buf.sv
module page_stage_buf
  import page_stage_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned AW = $clog2(PAGE_BYTES),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          shift_i,
  input  logic [7:0]    data_i,
  input  logic          flush_i,
  input  logic          pop_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o
);
  logic          wr_fire;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  byte_t         head;

  page_stage_ctrl #(.PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (wr_en_i & shift_i),
    .pop_i     (pop_i),
    .flush_i   (flush_i),
    .wr_fire_o (wr_fire),
    .wr_ptr_o  (wr_ptr),
    .rd_ptr_o  (rd_ptr),
    .count_o   (cnt)
  );

  page_stage_mem #(.PAGE_BYTES(PAGE_BYTES)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_fire),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (data_i),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (head)
  );

  assign rd_data_o  = head;
  assign count_o    = cnt;
  assign empty_o    = (cnt == '0);
  assign rd_valid_o = ~empty_o;
endmodule

// File: rtl/page_stage_chk.sv
module page_stage_chk #(
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned CW = $clog2(PAGE_BYTES) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          shift_i,
  input logic          flush_i,
  input logic          pop_i,
  input logic [7:0]    rd_data_o,
  input logic          rd_valid_o,
  input logic [CW-1:0] count_o,
  input logic          empty_o
);
  logic cap, full;
  assign cap  = wr_en_i & shift_i;
  assign full = (count_o == CW'(PAGE_BYTES));

  // R1
  a_r1_capture_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap && !flush_i && !pop_i && !full |=> count_o == $past(count_o) + 1'b1);
  // R2
  a_r2_no_capture_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap && !pop_i && !flush_i |=> $stable(count_o) && $stable(rd_data_o));
  // R3
  a_r3_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !pop_i && !flush_i && !(cap && full) |=> $stable(rd_data_o));
  // R4 / R5
  a_r5_never_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(PAGE_BYTES));
  a_r5_keep_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && cap && !flush_i |=> full);
  // R6
  a_r6_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o && count_o == '0);
  // R7
  a_r7_pop_empty_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !cap && !flush_i |=> empty_o);
  // R8
  a_r8_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && rd_valid_o && !cap && !flush_i |=> count_o == $past(count_o) - 1'b1);
  a_r8_pop_push_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && rd_valid_o && cap && !flush_i |=> $stable(count_o));
endmodule

bind page_stage_buf page_stage_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .shift_i    (shift_i),
  .flush_i    (flush_i),
  .pop_i      (pop_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .count_o    (count_o),
  .empty_o    (empty_o)
);

// File: tb/sim_page_stage_buf.sv
`timescale 1ns/1ps
module sim_page_stage_buf;
  localparam int unsigned PB = 8;
  localparam int unsigned CW = $clog2(PB) + 1;
  // {wr_en, shift, flush, pop, data}
  localparam int NV = 22;
  localparam logic [11:0] VEC [NV] = '{
    12'hC_A1, 12'hC_A2, 12'h0_00, 12'h0_00, 12'hC_A3,
    12'h4_EE, 12'h8_EE, 12'h0_00, 12'hC_A4, 12'h1_00,
    12'h0_00, 12'hD_A5, 12'hD_A6, 12'h1_00, 12'h8_FF,
    12'h1_00, 12'h1_00, 12'h1_00, 12'h1_00, 12'hC_B0,
    12'h0_00, 12'h1_00
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, shift = 0, flush = 0, pop = 0;
  logic [7:0] din = '0, rdat;
  logic rvalid, empty;
  logic [CW-1:0] cnt;
  int tests = 0, fails = 0;
  logic [7:0] q[$];

  always #2 clk = ~clk;

  page_stage_buf #(.PAGE_BYTES(PB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .shift_i(shift),
    .data_i(din), .flush_i(flush), .pop_i(pop), .rd_data_o(rdat),
    .rd_valid_o(rvalid), .count_o(cnt), .empty_o(empty)
  );

  task automatic expect_eq(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_model(input string tag);
    expect_eq({tag, " count"}, int'(cnt), q.size());
    expect_eq({tag, " empty R7"}, int'(empty), int'(q.size() == 0));
    expect_eq({tag, " valid R7"}, int'(rvalid), int'(q.size() != 0));
    if (q.size() != 0) expect_eq({tag, " head R3"}, int'(rdat), int'(q[0]));
  endtask

  task automatic step(input logic w, input logic s, input logic f, input logic p,
                      input logic [7:0] d);
    wr_en = w; shift = s; flush = f; pop = p; din = d;
    @(posedge clk);
    if (f) q.delete();
    else begin
      if (p && q.size() != 0) void'(q.pop_front());
      if (w && s) begin
        q.push_back(d);
        if (q.size() > PB) void'(q.pop_front());
      end
    end
    @(negedge clk);
    wr_en = 0; shift = 0; flush = 0; pop = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    expect_eq("R9 count after reset", int'(cnt), 0);
    expect_eq("R9 empty after reset", int'(empty), 1);

    // R1 R2 R4 R8 table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
      check_model($sformatf("R1/R2/R8 vec%0d", i));
    end

    // R6 flush beats capture
    step(1, 1, 0, 0, 8'h33);
    step(1, 1, 1, 1, 8'h44);
    expect_eq("R6 flush with capture count", int'(cnt), 0);
    check_model("R6");

    // R7 pop while empty ignored
    step(0, 0, 0, 1, 8'h00);
    expect_eq("R7 pop on empty", int'(cnt), 0);

    // R4 fill exactly one page with gaps
    for (int i = 0; i < PB; i++) begin
      step(1, 1, 0, 0, 8'h60 + 8'(i));
      step(0, 0, 0, 0, 8'h00);
    end
    expect_eq("R4 full count", int'(cnt), PB);
    expect_eq("R4 head first byte", int'(rdat), 8'h60);

    // R5 overflow by three keeps last page
    step(0, 0, 1, 0, 8'h00);
    for (int i = 0; i < PB + 3; i++) step(1, 1, 0, 0, 8'h10 + 8'(i));
    expect_eq("R5 count stays full", int'(cnt), PB);
    expect_eq("R5 head after drop", int'(rdat), 8'h13);
    for (int i = 0; i < PB; i++) begin
      expect_eq("R5 drain order", int'(rdat), 8'h13 + i);
      step(0, 0, 0, 1, 8'h00);
    end
    expect_eq("R5 empty after drain", int'(empty), 1);

    // R8 capture and pop while full
    for (int i = 0; i < PB; i++) step(1, 1, 0, 0, 8'h80 + 8'(i));
    step(1, 1, 0, 1, 8'hC0);
    expect_eq("R8 full push+pop count", int'(cnt), PB);
    expect_eq("R8 full push+pop head", int'(rdat), 8'h81);
    check_model("R8");

    // R2 write enable without strobe, strobe without enable
    step(1, 0, 0, 0, 8'h55);
    step(0, 1, 0, 0, 8'h66);
    check_model("R2 ignored");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule